// File: doc/BRIEF.md
# Thread Block Barrier Unit

This unit provides the synchronization point for the warps of one resident thread block. When a warp reaches a barrier it sends an arrival. The arrival carries the warp number, a small barrier-site identifier and the mask of its threads that took part. The unit holds each arriving warp in a stalled state. Once every live thread of every warp still present in the block has arrived at the same site, the unit frees all of them in a single cycle.

The expected set of threads comes from a per-warp live mask input. A warp that finishes early sends an exit notice, which removes it from the expected set, so the remaining warps can still complete. Barrier sites are matched by identity. An arrival at a site other than the one already pending is an error: it is held stalled and never helps complete the barrier. A block that makes no arrival for a programmable number of cycles while a barrier is pending raises a deadlock flag. Synchronization across blocks and memory ordering are handled elsewhere.

Top module: `block_barrier`

## Requirements
- R1: After reset, stall_o, release_o, deadlock_o and site_err_o are all zero.
- R2: An arrival that does not complete the barrier sets stall_o bit w, where w is arr_warp_i, from the cycle after the arrival. That bit stays set until release.
- R3: The barrier completes when every warp has arrived with its whole live mask, or has exited, and the arrivals share one site. On completion, release_o is high for exactly one cycle, the cycle after the completing event. stall_o becomes all zero in that same cycle.
- R4: Arrival masks from one warp accumulate by bitwise OR. A warp whose accumulated mask does not yet cover its live mask keeps the barrier incomplete.
- R5: An arrival whose site differs from the pending site sets site_err_o. site_err_o stays set until reset. That arrival is stalled, and no release occurs while site_err_o is set, even when all masks are covered.
- R6: An exit notice removes that warp from the expected set. An exit of the last missing warp completes the barrier. An arrival and an exit in the same cycle are both counted.
- R7: A warp whose live mask is zero is not waited for.
- R8: While a barrier is pending, deadlock_o rises once idle_limit_i cycles have passed with no arrival. An arrival clears deadlock_o and restarts the count. A release clears deadlock_o.
- R9: After a release, the next barrier may use any site without raising site_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_mask_i | input | NW*WT | Live-thread mask; warp w occupies bits [w*WT +: WT] |
| arr_valid_i | input | 1 | Arrival strobe |
| arr_warp_i | input | log2(NW) | Arriving warp number |
| arr_site_i | input | 4 | Barrier site identifier |
| arr_mask_i | input | WT | Threads of the warp that arrived |
| exit_valid_i | input | 1 | Warp exit notice strobe |
| exit_warp_i | input | log2(NW) | Exiting warp number |
| idle_limit_i | input | TO_W | Idle cycles before deadlock is flagged |
| stall_o | output | NW | Per-warp stall |
| release_o | output | 1 | One-cycle barrier release pulse |
| deadlock_o | output | 1 | Barrier pending and idle past the limit |
| site_err_o | output | 1 | Sticky site mismatch error |

## Verification
Two events can fall in one cycle. The first is an arrival together with the exit notice of the only other missing warp. The bench drives both strobes on the same edge and expects a release on the next cycle with every stall bit cleared. The second is a site mismatch that arrives just as the masks become fully covered. Here the bench expects the mismatching warp to be stalled, site_err_o to be set and no release to occur, followed later by the deadlock flag.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    localparam int SITE_W = 4;
    typedef logic [SITE_W-1:0] site_t;
endpackage

// File: rtl/bar_warp_cover.sv
module bar_warp_cover #(
    parameter int WT = 32
) (
    input  logic [WT-1:0] live_i,
    input  logic [WT-1:0] got_i,
    input  logic          gone_i,
    output logic          done_o
);
    always_comb begin
        done_o = gone_i | ((live_i & ~got_i) == '0);
    end
endmodule

// File: rtl/bar_idle_timer.sv
module bar_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             stuck_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stuck;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!armed_i || kick_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != '1) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        tmr_d.stuck = armed_i && (tmr_d.cnt >= limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign stuck_o = tmr_q.stuck;

    // R8: an arrival with a nonzero limit always clears the flag
    p_kick_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && limit_i != '0) |=> !stuck_o);
endmodule

// File: rtl/block_barrier.sv
module block_barrier
    import barrier_pkg::*;
#(
    parameter int NW   = 32,
    parameter int WT   = 32,
    parameter int TO_W = 16,
    localparam int WW  = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW*WT-1:0] live_mask_i,
    input  logic             arr_valid_i,
    input  logic [WW-1:0]    arr_warp_i,
    input  logic [SITE_W-1:0] arr_site_i,
    input  logic [WT-1:0]    arr_mask_i,
    input  logic             exit_valid_i,
    input  logic [WW-1:0]    exit_warp_i,
    input  logic [TO_W-1:0]  idle_limit_i,
    output logic [NW-1:0]    stall_o,
    output logic             release_o,
    output logic             deadlock_o,
    output logic             site_err_o
);
    typedef struct packed {
        logic [NW*WT-1:0] got;
        logic [NW-1:0]    gone;
        logic [NW-1:0]    stall;
        site_t            site;
        logic             pend;
        logic             err;
        logic             rel;
    } bar_t;

    bar_t st_q, mid_d, st_d;
    logic [NW-1:0] done_w;

    // Merge this cycle's arrival and exit into the held state.
    always_comb begin
        mid_d     = st_q;
        mid_d.rel = 1'b0;
        if (exit_valid_i) begin
            mid_d.gone[exit_warp_i] = 1'b1;
        end
        if (arr_valid_i) begin
            if (st_q.pend && arr_site_i != st_q.site) mid_d.err = 1'b1;
            if (!st_q.pend) mid_d.site = arr_site_i;
            mid_d.pend = 1'b1;
            mid_d.got[int'(arr_warp_i)*WT +: WT] =
                st_q.got[int'(arr_warp_i)*WT +: WT] | arr_mask_i;
            mid_d.stall[arr_warp_i] = 1'b1;
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_cover
        bar_warp_cover #(.WT(WT)) u_cover (
            .live_i (live_mask_i[w*WT +: WT]),
            .got_i  (mid_d.got[w*WT +: WT]),
            .gone_i (mid_d.gone[w]),
            .done_o (done_w[w])
        );
    end

    // Release when every warp is covered and no site mismatch was seen.
    always_comb begin
        st_d = mid_d;
        if (mid_d.pend && !mid_d.err && (&done_w)) begin
            st_d.got   = '0;
            st_d.stall = '0;
            st_d.pend  = 1'b0;
            st_d.rel   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bar_idle_timer #(.CNT_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_i (st_d.pend),
        .kick_i  (arr_valid_i),
        .limit_i (idle_limit_i),
        .stuck_o (deadlock_o)
    );

    assign stall_o    = st_q.stall;
    assign release_o  = st_q.rel;
    assign site_err_o = st_q.err;

    // R3: every stall bit is clear in the release cycle
    p_release_drops_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (stall_o == '0));
    // R2: a stall bit rises only after an arrival
    p_stall_needs_arrival_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(arr_valid_i) |-> ((stall_o & ~$past(stall_o)) == '0));
    // R5: a mismatch blocks release
    p_err_blocks_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        site_err_o |-> !release_o);
    // R5: the mismatch error is sticky
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        site_err_o |=> site_err_o);
    // R8: deadlock only while some warp is held
    p_dead_has_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock_o |-> (stall_o != '0));
endmodule

// File: tb/tb_block_barrier.sv
module tb_block_barrier;
    localparam int NW = 4;
    localparam int WT = 4;
    localparam int TO_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW*WT-1:0] live_mask_i;
    logic arr_valid_i = 1'b0;
    logic [1:0] arr_warp_i = '0;
    logic [3:0] arr_site_i = '0;
    logic [WT-1:0] arr_mask_i = '0;
    logic exit_valid_i = 1'b0;
    logic [1:0] exit_warp_i = '0;
    logic [TO_W-1:0] idle_limit_i = 8'd200;
    logic [NW-1:0] stall_o;
    logic release_o, deadlock_o, site_err_o;
    logic [WT-1:0] live [NW];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int w = 0; w < NW; w++) live_mask_i[w*WT +: WT] = live[w];
    end

    block_barrier #(.NW(NW), .WT(WT), .TO_W(TO_W)) dut (
        .clk(clk), .rst_n(rst_n), .live_mask_i(live_mask_i),
        .arr_valid_i(arr_valid_i), .arr_warp_i(arr_warp_i),
        .arr_site_i(arr_site_i), .arr_mask_i(arr_mask_i),
        .exit_valid_i(exit_valid_i), .exit_warp_i(exit_warp_i),
        .idle_limit_i(idle_limit_i), .stall_o(stall_o),
        .release_o(release_o), .deadlock_o(deadlock_o), .site_err_o(site_err_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        arr_valid_i = 1'b0;
        exit_valid_i = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic arrive(input int w, input logic [3:0] site, input logic [WT-1:0] m);
        arr_valid_i = 1'b1;
        arr_warp_i = 2'(w);
        arr_site_i = site;
        arr_mask_i = m;
        step();
        arr_valid_i = 1'b0;
    endtask

    task automatic leave(input int w);
        exit_valid_i = 1'b1;
        exit_warp_i = 2'(w);
        step();
        exit_valid_i = 1'b0;
    endtask

    task automatic all_live();
        for (int w = 0; w < NW; w++) live[w] = '1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NW-1:0] exp_stall;
        int last;
        all_live();
        do_reset();
        chk("R1 stall", 32'(stall_o), 0);
        chk("R1 release", 32'(release_o), 0);
        chk("R1 deadlock", 32'(deadlock_o), 0);
        chk("R1 site_err", 32'(site_err_o), 0);

        // R2 R3 R7: sweep every set of live warps, arrive in index order
        for (int cfg = 1; cfg < 16; cfg++) begin
            for (int w = 0; w < NW; w++) live[w] = cfg[w] ? 4'hF : 4'h0;
            do_reset();
            exp_stall = '0;
            last = 0;
            for (int w = 0; w < NW; w++) if (cfg[w]) last = w;
            for (int w = 0; w < NW; w++) begin
                if (cfg[w]) begin
                    arrive(w, 4'd3, 4'hF);
                    if (w == last) begin
                        chk("R3 release on final arrival", 32'(release_o), 1);
                        chk("R3 stall cleared", 32'(stall_o), 0);
                    end else begin
                        exp_stall[w] = 1'b1;
                        chk("R2 stall held", 32'(stall_o), 32'(exp_stall));
                        chk("R7 no early release", 32'(release_o), 0);
                    end
                end
            end
            step();
            chk("R3 single pulse", 32'(release_o), 0);
        end

        // R6: each warp in turn exits instead of arriving
        all_live();
        for (int e = 0; e < NW; e++) begin
            do_reset();
            for (int w = 0; w < NW; w++) if (w != e) arrive(w, 4'd2, 4'hF);
            chk("R6 waiting on exiter", 32'(release_o), 0);
            leave(e);
            chk("R6 exit completes", 32'(release_o), 1);
            chk("R6 stall cleared", 32'(stall_o), 0);
        end

        // R6: arrival and exit in the same cycle
        do_reset();
        arrive(0, 4'd1, 4'hF);
        arrive(1, 4'd1, 4'hF);
        exit_valid_i = 1'b1;
        exit_warp_i = 2'd3;
        arrive(2, 4'd1, 4'hF);
        exit_valid_i = 1'b0;
        chk("R6 same-cycle arrive+exit release", 32'(release_o), 1);
        chk("R6 same-cycle stall", 32'(stall_o), 0);

        // R4: partial masks accumulate
        live[0] = 4'hF;
        for (int w = 1; w < NW; w++) live[w] = 4'h0;
        do_reset();
        arrive(0, 4'd4, 4'h3);
        chk("R4 partial holds", 32'(release_o), 0);
        chk("R4 partial stall", 32'(stall_o), 1);
        arrive(0, 4'd4, 4'hC);
        chk("R4 covered releases", 32'(release_o), 1);

        // R9: new barrier with another site after release
        arrive(0, 4'd9, 4'hF);
        chk("R9 new site no error", 32'(site_err_o), 0);
        chk("R9 new barrier releases", 32'(release_o), 1);

        // R5 and R8: mismatch blocks release, then deadlock rises
        all_live();
        idle_limit_i = 8'd5;
        do_reset();
        arrive(0, 4'd1, 4'hF);
        arrive(1, 4'd2, 4'hF);
        chk("R5 mismatch flagged", 32'(site_err_o), 1);
        chk("R5 mismatching warp stalled", 32'(stall_o), 32'h3);
        arrive(2, 4'd1, 4'hF);
        arrive(3, 4'd1, 4'hF);
        chk("R5 no release on mismatch", 32'(release_o), 0);
        chk("R5 all stalled", 32'(stall_o), 32'hF);
        repeat (4) step();
        chk("R8 not yet deadlocked", 32'(deadlock_o), 0);
        step();
        chk("R8 deadlock after limit", 32'(deadlock_o), 1);
        chk("R5 error sticky", 32'(site_err_o), 1);

        // R8: arrival restarts count, release clears
        do_reset();
        arrive(0, 4'd6, 4'hF);
        repeat (5) step();
        chk("R8 deadlock raised", 32'(deadlock_o), 1);
        arrive(1, 4'd6, 4'hF);
        chk("R8 arrival clears deadlock", 32'(deadlock_o), 0);
        repeat (4) step();
        chk("R8 count restarted", 32'(deadlock_o), 0);
        arrive(2, 4'd6, 4'hF);
        arrive(3, 4'd6, 4'hF);
        chk("R8 release", 32'(release_o), 1);
        repeat (6) step();
        chk("R8 no deadlock after release", 32'(deadlock_o), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule